// File: doc/BRIEF.md
# Endpoint-Zero Control Transfer Stage Sequencer

This block follows a device's control transfer on endpoint 0 through its stages without CPU intervention for the sequencing itself. The packet engine hands it one decoded token per cycle (SETUP, IN or OUT) together with the 8-byte request that came with a SETUP. The block answers each token at once with a handshake choice (ACK, NAK or STALL), which the packet engine then sends on the wire.

The block reads two things from each new request: whether a data stage follows and, if it does, which direction it runs. From these it sorts the transfer into one of three types: read, write or no-data. The CPU drives three strobes. One releases the current stage. One arms the next data packet. One requests a protocol stall. The block raises a one-cycle interrupt for every SETUP it accepts.

A token that belongs to the following stage but arrives before the CPU has released the current one is held off with NAK. A SETUP always wins: it ends whatever transfer was running and restarts the setup stage.

Top module: `ep0_stage_seq`

## Requirements
- R1: After reset the stage is idle (code 0), the type is no-data (code 0), busy is low and no setup interrupt is raised.
- R2: On a SETUP token the type is latched from the request. Bit 7 of byte 0 (setupData bit 7) set means device-to-host. Bytes 6..7 (setupData[63:48], little-endian) hold the length, and a non-zero length means a data stage follows. The type codes are: no-data = 0 when the length is zero; read = 1 when the length is non-zero and the direction is device-to-host; write = 2 otherwise. The type holds between SETUP tokens.
- R3: A SETUP token (tokKind 1) is always answered ACK (hsCode 1) in any stage. The next cycle shows stage setup (code 1), and setupIrq is high for exactly that one cycle, for every SETUP including back-to-back ones.
- R4: In the setup stage, cpuStageDone moves the stage to data (code 2) when a data stage exists, or to status (code 3) for a no-data transfer.
- R5: In the data stage, a token in the data direction (IN for read, OUT for write; tokKind 2 = IN, 3 = OUT) gets ACK only if cpuDataRdy has pulsed since the last such ACK or since the SETUP; otherwise it gets NAK (hsCode 2). cpuStageDone in the data stage moves to status.
- R6: A token of the stage that follows the current one, arriving before the CPU has released the current stage, gets NAK and leaves the stage unchanged. In the setup stage that is the data-direction token, or the status-direction token when there is no data stage. In the data stage it is the status-direction token.
- R7: In the setup, data or status stage, a token that fits neither the current nor the following stage gets STALL (hsCode 3), and the stage becomes stall (code 4).
- R8: cpuStall in the setup, data or status stage moves the stage to stall. In the stall stage every IN or OUT token gets STALL and the stage stays there until a SETUP.
- R9: The status stage runs opposite to the data stage, and IN for a no-data transfer. A status-direction token there gets ACK, and the stage returns to idle on the next cycle.
- R10: In the idle stage, IN and OUT tokens get STALL and the stage stays idle.
- R11: busy is high exactly while the stage is setup or data.
- R12: With no token (tokKind 0) hsCode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokKind | input | 2 | Token this cycle: 0 none, 1 SETUP, 2 IN, 3 OUT |
| setupData | input | 64 | Request bytes, byte k at bits 8k+7..8k, sampled with a SETUP |
| cpuStageDone | input | 1 | CPU strobe releasing the current stage |
| cpuDataRdy | input | 1 | CPU strobe arming one data-stage packet |
| cpuStall | input | 1 | CPU strobe requesting a protocol stall |
| hsCode | output | 2 | Handshake for this cycle's token: 0 none, 1 ACK, 2 NAK, 3 STALL |
| stage | output | 3 | Stage: 0 idle, 1 setup, 2 data, 3 status, 4 stall |
| xferType | output | 2 | Transfer type: 0 no-data, 1 read, 2 write |
| busy | output | 1 | High while a next-stage token would be held off |
| setupIrq | output | 1 | One-cycle interrupt after each SETUP |

## Verification
The handshake is combinational: it is due in the same cycle as the token and depends on the stage as it stood before that token. The stage, type, busy flag and interrupt are registered and show the effect of a token or strobe one clock edge later. The bench drives each cycle's inputs just after the falling edge and compares everything one time step later. At that point the handshake must reflect the reference model's state before its update, and the registered outputs must reflect every earlier cycle's update. The model then advances, so an off-by-one-cycle design shows up as a mismatch on the next compare.

// File: rtl/ep0_pkg.sv
package ep0_pkg;

  typedef enum logic [1:0] {
    TOK_NONE  = 2'd0,
    TOK_SETUP = 2'd1,
    TOK_IN    = 2'd2,
    TOK_OUT   = 2'd3
  } tok_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_DATA   = 3'd2,
    ST_STATUS = 3'd3,
    ST_STALL  = 3'd4
  } stage_e;

  typedef enum logic [1:0] {
    XF_NODATA = 2'd0,
    XF_READ   = 2'd1,
    XF_WRITE  = 2'd2
  } xfer_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  // strobes from the stage control to the request datapath
  typedef struct packed {
    logic latchSetup;  // capture a new request, clear armed packet
    logic takeData;    // one armed data packet was acknowledged
  } ctlStrobe_t;

endpackage

// File: rtl/ep0_dpath.sv
module ep0_dpath
  import ep0_pkg::*;
#(
  parameter int SETUP_W = 64,
  parameter int DIR_POS = 7,
  parameter int LEN_LSB = 48,
  parameter int LEN_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SETUP_W-1:0] setupData,
  input  ctlStrobe_t         strb,
  input  logic               cpuDataRdy,
  output xfer_e              xferType,
  output logic               dataRdy,
  output logic               setupIrq
);

  logic  lenNonZero;
  logic  toHost;
  xfer_e decodedType;

  always_comb begin
    lenNonZero = |setupData[LEN_LSB +: LEN_W];
    toHost     = setupData[DIR_POS];
    if (!lenNonZero)  decodedType = XF_NODATA;
    else if (toHost)  decodedType = XF_READ;
    else              decodedType = XF_WRITE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferType <= XF_NODATA;
      dataRdy  <= 1'b0;
      setupIrq <= 1'b0;
    end else begin
      setupIrq <= strb.latchSetup;
      if (strb.latchSetup) begin
        xferType <= decodedType;
        dataRdy  <= 1'b0;
      end else begin
        dataRdy  <= (dataRdy & ~strb.takeData) | cpuDataRdy;
      end
    end
  end

  // R3: every SETUP strobe from the control yields an interrupt next cycle
  assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchSetup |=> setupIrq);

  // R2: the type only changes when a request is captured
  assert_type_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchSetup |=> $stable(xferType));

  // R5: an acknowledged packet with no new arming leaves nothing armed
  assert_rdy_consumed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeData && !cpuDataRdy && !strb.latchSetup) |=> !dataRdy);

endmodule

// File: rtl/ep0_ctrl.sv
module ep0_ctrl
  import ep0_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tok_e       tok,
  input  logic       cpuStageDone,
  input  logic       cpuStall,
  input  xfer_e      xferType,
  input  logic       dataRdy,
  output stage_e     stage,
  output hs_e        hs,
  output ctlStrobe_t strb,
  output logic       busy
);

  stage_e stageNext;
  tok_e   dataTok;
  tok_e   statTok;
  tok_e   curTok;
  tok_e   nextTok;
  logic   active;
  logic   wrongTok;

  // which token the current stage and the following stage expect
  always_comb begin
    dataTok = (xferType == XF_READ) ? TOK_IN : TOK_OUT;
    statTok = (xferType == XF_READ) ? TOK_OUT : TOK_IN;
    curTok  = TOK_NONE;
    nextTok = TOK_NONE;
    case (stage)
      ST_SETUP:  nextTok = (xferType == XF_NODATA) ? statTok : dataTok;
      ST_DATA:   begin curTok = dataTok; nextTok = statTok; end
      ST_STATUS: curTok = statTok;
      default:   ;
    endcase
    active = (stage == ST_SETUP) || (stage == ST_DATA) || (stage == ST_STATUS);
  end

  // handshake choice for this cycle's token
  always_comb begin
    wrongTok = 1'b0;
    if (tok == TOK_NONE)        hs = HS_NONE;
    else if (tok == TOK_SETUP)  hs = HS_ACK;
    else if (!active)           hs = HS_STALL;
    else if (tok == curTok)     hs = (stage == ST_DATA && !dataRdy) ? HS_NAK : HS_ACK;
    else if (tok == nextTok)    hs = HS_NAK;
    else begin
      hs       = HS_STALL;
      wrongTok = 1'b1;
    end
  end

  always_comb begin
    strb.latchSetup = (tok == TOK_SETUP);
    strb.takeData   = (stage == ST_DATA) && (tok == curTok) && dataRdy;
  end

  always_comb begin
    stageNext = stage;
    if (tok == TOK_SETUP)                          stageNext = ST_SETUP;
    else if (active && (cpuStall || wrongTok))     stageNext = ST_STALL;
    else if (stage == ST_STATUS && hs == HS_ACK)   stageNext = ST_IDLE;
    else if (cpuStageDone && stage == ST_SETUP)
      stageNext = (xferType == XF_NODATA) ? ST_STATUS : ST_DATA;
    else if (cpuStageDone && stage == ST_DATA)     stageNext = ST_STATUS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stage <= ST_IDLE;
    else       stage <= stageNext;
  end

  assign busy = (stage == ST_SETUP) || (stage == ST_DATA);

  // R3: a SETUP restarts the setup stage from anywhere
  assert_setup_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tok == TOK_SETUP) |=> (stage == ST_SETUP));

  // R6: a held-off token in the setup stage keeps the stage
  assert_nak_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stage == ST_SETUP && hs == HS_NAK && !cpuStageDone && !cpuStall) |=> (stage == ST_SETUP));

  // R8: the stall stage is left only through a SETUP
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stage == ST_STALL && tok != TOK_SETUP) |=> (stage == ST_STALL));

  // R9: an acknowledged status token ends the transfer
  assert_status_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stage == ST_STATUS && hs == HS_ACK && tok != TOK_SETUP) |=> (stage == ST_IDLE));

  // R10: idle only moves on a SETUP
  assert_idle_stay_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stage == ST_IDLE && tok != TOK_SETUP) |=> (stage == ST_IDLE));

endmodule

// File: rtl/ep0_stage_seq.sv
module ep0_stage_seq #(
  parameter int SETUP_BYTES = 8,
  parameter int DIR_BYTE    = 0,
  parameter int DIR_BIT     = 7,
  parameter int LEN_BYTE    = 6,
  parameter int LEN_BYTES   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               tokKind,
  input  logic [SETUP_BYTES*8-1:0] setupData,
  input  logic                     cpuStageDone,
  input  logic                     cpuDataRdy,
  input  logic                     cpuStall,
  output logic [1:0]               hsCode,
  output logic [2:0]               stage,
  output logic [1:0]               xferType,
  output logic                     busy,
  output logic                     setupIrq
);
  import ep0_pkg::*;

  localparam int SETUP_W = SETUP_BYTES * 8;
  localparam int DIR_POS = DIR_BYTE * 8 + DIR_BIT;
  localparam int LEN_LSB = LEN_BYTE * 8;
  localparam int LEN_W   = LEN_BYTES * 8;

  ctlStrobe_t strb;
  xfer_e      typeQ;
  logic       dataRdy;
  stage_e     stageQ;
  hs_e        hsQ;

  ep0_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tok          (tok_e'(tokKind)),
    .cpuStageDone (cpuStageDone),
    .cpuStall     (cpuStall),
    .xferType     (typeQ),
    .dataRdy      (dataRdy),
    .stage        (stageQ),
    .hs           (hsQ),
    .strb         (strb),
    .busy         (busy)
  );

  ep0_dpath #(
    .SETUP_W (SETUP_W),
    .DIR_POS (DIR_POS),
    .LEN_LSB (LEN_LSB),
    .LEN_W   (LEN_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .setupData  (setupData),
    .strb       (strb),
    .cpuDataRdy (cpuDataRdy),
    .xferType   (typeQ),
    .dataRdy    (dataRdy),
    .setupIrq   (setupIrq)
  );

  assign hsCode   = hsQ;
  assign stage    = stageQ;
  assign xferType = typeQ;

  // R3: SETUP tokens are never held off or stalled
  assert_setup_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tokKind == 2'd1) |-> (hsCode == 2'd1));

  // R11: busy implies a stage where the CPU still owns the transfer
  assert_busy_stage_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stage == 3'd1 || stage == 3'd2));

endmodule

// File: tb/sim_ep0_stage_seq.sv
module sim_ep0_stage_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  tokKind = 2'd0;
  logic [63:0] setupData = 64'd0;
  logic        cpuStageDone = 1'b0;
  logic        cpuDataRdy = 1'b0;
  logic        cpuStall = 1'b0;
  wire  [1:0]  hsCode;
  wire  [2:0]  stage;
  wire  [1:0]  xferType;
  wire         busy;
  wire         setupIrq;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;

  // reference model state
  int mStage = 0, mType = 0, mRdy = 0, mIrq = 0;

  always #10 clk = ~clk;  // 50 MHz

  ep0_stage_seq u0 (
    .clk(clk), .rstN(rstN), .tokKind(tokKind), .setupData(setupData),
    .cpuStageDone(cpuStageDone), .cpuDataRdy(cpuDataRdy), .cpuStall(cpuStall),
    .hsCode(hsCode), .stage(stage), .xferType(xferType), .busy(busy),
    .setupIrq(setupIrq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] req(input logic [7:0] b0, input logic [15:0] len);
    return {len, 40'h5A_C3_3C_A5_96, b0};
  endfunction

  // expected handshake: 0 none, 1 ack, 2 nak, 3 stall; tokens 2 IN, 3 OUT
  function automatic int expectHs(input int tk);
    int want, after;
    int inDir  = 2;
    int outDir = 3;
    int dDir   = (mType == 1) ? inDir : outDir;
    int sDir   = (mType == 1) ? outDir : inDir;
    if (tk == 0) return 0;
    if (tk == 1) return 1;
    want = -1; after = -1;
    if (mStage == 1) after = (mType == 0) ? sDir : dDir;
    else if (mStage == 2) begin want = dDir; after = sDir; end
    else if (mStage == 3) want = sDir;
    else return 3;
    if (tk == want) return (mStage == 2 && mRdy == 0) ? 2 : 1;
    if (tk == after) return 2;
    return 3;
  endfunction

  task automatic tick(input string rq, input int tk, input logic [63:0] sd,
                      input bit sDone, input bit dRdy, input bit stl);
    int eh, nStage;
    bit act;
    @(negedge clk);
    tokKind = tk[1:0]; setupData = sd;
    cpuStageDone = sDone; cpuDataRdy = dRdy; cpuStall = stl;
    #1;
    eh = expectHs(tk);
    check(rq, "hsCode", hsCode, eh);
    check(rq, "stage", stage, mStage);
    check(rq, "xferType", xferType, mType);
    check("R11", "busy", busy, (mStage == 1 || mStage == 2) ? 1 : 0);
    check(rq, "setupIrq", setupIrq, mIrq);
    // advance model
    act = (mStage >= 1 && mStage <= 3);
    nStage = mStage;
    mIrq = (tk == 1) ? 1 : 0;
    if (tk == 1) begin
      if (sd[63:48] == 0) mType = 0;
      else mType = sd[7] ? 1 : 2;
      mRdy = 0;
      nStage = 1;
    end else begin
      if (mStage == 2 && eh == 1) mRdy = 0;
      if (dRdy) mRdy = 1;
      if (act && (stl || (tk >= 2 && eh == 3))) nStage = 4;
      else if (mStage == 3 && eh == 1) nStage = 0;
      else if (sDone && mStage == 1) nStage = (mType == 0) ? 3 : 2;
      else if (sDone && mStage == 2) nStage = 3;
    end
    mStage = nStage;
  endtask

  initial begin
    // R1: reset values
    repeat (3) begin
      @(negedge clk); #1;
      check("R1", "stage", stage, 0);
      check("R1", "xferType", xferType, 0);
      check("R1", "busy", busy, 0);
      check("R1", "setupIrq", setupIrq, 0);
    end
    @(negedge clk); rstN = 1'b1;

    // R12, R10: idle behaviour
    tick("R12", 0, 0, 0, 0, 0);
    tick("R10", 2, 0, 0, 0, 0);
    tick("R10", 3, 0, 0, 0, 0);
    tick("R10", 0, 0, 0, 0, 0);

    // control read, length 0x0040
    tick("R3", 1, req(8'h81, 16'h0040), 0, 0, 0);
    tick("R2", 0, 0, 0, 0, 0);
    tick("R6", 2, 0, 0, 0, 0);          // data token before release
    tick("R4", 0, 0, 1, 0, 0);          // release setup -> data
    tick("R5", 2, 0, 0, 0, 0);          // not armed -> NAK
    tick("R5", 0, 0, 0, 1, 0);          // arm
    tick("R5", 2, 0, 0, 0, 0);          // ACK
    tick("R5", 2, 0, 0, 0, 0);          // consumed -> NAK
    tick("R6", 3, 0, 0, 0, 0);          // status token early
    tick("R5", 0, 0, 1, 1, 0);          // release data -> status
    tick("R9", 3, 0, 0, 0, 0);          // status OUT ACK
    tick("R9", 0, 0, 0, 0, 0);

    // control write, length only in high byte
    tick("R2", 1, req(8'h00, 16'h0100), 0, 0, 0);
    tick("R7", 2, 0, 0, 0, 0);          // IN fits neither stage -> stall
    tick("R8", 3, 0, 0, 0, 0);
    tick("R3", 1, req(8'h00, 16'h0100), 0, 1, 0);
    tick("R4", 0, 0, 1, 0, 0);
    tick("R5", 3, 0, 0, 1, 0);          // NAK, armed same cycle
    tick("R5", 3, 0, 1, 0, 0);          // ACK and release
    tick("R9", 3, 0, 0, 0, 0);          // wrong dir in status -> stall
    tick("R8", 2, 0, 0, 0, 0);

    // no-data, direction bit set but zero length
    tick("R2", 1, req(8'h80, 16'h0000), 0, 0, 0);
    tick("R6", 2, 0, 0, 0, 0);          // status IN before release
    tick("R7", 3, 0, 0, 0, 0);          // OUT -> stall
    tick("R3", 1, req(8'h80, 16'h0000), 0, 0, 0);
    tick("R3", 1, req(8'h00, 16'h0000), 0, 0, 0);   // back-to-back
    tick("R4", 0, 0, 1, 0, 0);          // setup -> status
    tick("R9", 2, 0, 0, 0, 0);
    tick("R10", 2, 0, 0, 0, 0);

    // CPU stall in data, then abort by SETUP mid data stage
    tick("R3", 1, req(8'h80, 16'h0012), 0, 0, 0);
    tick("R4", 0, 0, 1, 0, 0);
    tick("R8", 0, 0, 0, 0, 1);
    tick("R8", 2, 0, 0, 1, 0);
    tick("R8", 3, 0, 1, 0, 0);
    tick("R3", 1, req(8'h00, 16'hFFFF), 0, 0, 0);
    tick("R4", 0, 0, 1, 0, 0);
    tick("R5", 0, 0, 0, 1, 0);
    tick("R3", 1, req(8'h80, 16'h0008), 0, 0, 0);   // abort in data
    tick("R5", 0, 0, 1, 0, 0);
    tick("R5", 2, 0, 0, 0, 0);          // old arming dropped -> NAK
    tick("R8", 0, 0, 0, 0, 1);
    tick("R8", 0, 0, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule